// File: doc/BRIEF.md
# Hardware Ticket Lock Unit

This block arbitrates one shared resource among a fixed number of requesters and guarantees that the resource is handed out strictly in arrival order. It keeps two wrapping counters: a dispense counter that numbers each new acquire, and a serving counter that names the ticket currently allowed to own the lock. A requester that pulses its acquire strobe is given the dispense count as its personal ticket in the same clock edge, and the dispense counter moves forward by one. The requester owns the lock for as long as its stored ticket matches the serving counter.

The owner pulses its release strobe when done. The serving counter then moves forward by one, and the requester holding the next ticket becomes owner without any new arbitration. Acquires that land in the same cycle are numbered in ascending requester-index order. A release from any requester that is not the current owner changes nothing except a one-cycle error flag. Both counter values are visible at the ports.

Top module: `ticket_lock_unit`

## Requirements
- R1: After reset both counters read 0, no grant is asserted and the error flag is low.
- R2: An acquire strobe from a requester that holds no ticket stores the current dispense count as its ticket and advances the dispense count by one at that clock edge; an acquire from a requester that already holds a ticket is ignored.
- R3: When several requesters without tickets strobe acquire in one cycle, the lowest index gets the current dispense count and each higher index the next value in turn, and the dispense count advances by the number of acquires accepted.
- R4: grant_o bit i is high exactly while requester i holds a ticket equal to the serving count; at most one bit is high, and an acquire that finds the serving count equal to the dispense count is granted in the cycle right after its clock edge.
- R5: A release strobe from the requester whose grant bit is high advances the serving count by one at that edge and drops that requester's ticket, so the next ticket holder is granted in the following cycle.
- R6: A release strobe from a requester whose grant bit is low leaves both counters and all grants unchanged and sets rel_err_o high for exactly the following cycle; rel_err_o is low after any cycle without such a strobe.
- R7: Both counters wrap modulo 2^TKT_W, and the dispense count minus the serving count (modulo 2^TKT_W) always equals the number of requesters holding a ticket.
- R8: Over any sequence, ownership passes between requesters in the same order in which their acquires were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acq_i | input | NUM_REQ | Per-requester acquire strobe |
| rel_i | input | NUM_REQ | Per-requester release strobe |
| grant_o | output | NUM_REQ | Per-requester lock ownership |
| next_ticket_o | output | TKT_W | Ticket value the next acquire will receive |
| now_serving_o | output | TKT_W | Ticket value that currently owns the lock |
| rel_err_o | output | 1 | High for one cycle after a release from a non-owner |

## Verification
Every result of this block is due one clock edge after its stimulus: a strobe sampled at an edge updates the counters, the stored tickets and the error flag at that edge, and the grant bits follow from those registers without further delay. The bench therefore drives strobes just after a falling edge, lets one rising edge pass, and compares every output with its reference model at the next falling edge, before new strobes are applied. Directed sequences cover simultaneous acquires, repeated acquires by a holder, releases by non-owners and the hand-over chain, while a long pseudo-random run pushes both counters through several wraps.

// File: rtl/ticket_lock_pkg.sv
package ticket_lock_pkg;

   // Classification of the release strobes seen in one cycle.
   typedef enum logic [1:0] {
      REL_NONE  = 2'd0,
      REL_OWNER = 2'd1,
      REL_BAD   = 2'd2,
      REL_BOTH  = 2'd3
   } rel_kind_e;

   // Smallest counter width that keeps every outstanding ticket distinct
   // and the outstanding count itself representable.
   function automatic int unsigned min_ticket_width(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((1 << w) <= n) w = w + 1;
      return w;
   endfunction

endpackage

// File: rtl/tkt_dispenser.sv
module tkt_dispenser #(
   parameter int unsigned NUM_REQ = 4,
   parameter int unsigned TKT_W   = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_REQ-1:0]              take_i,
   output logic [NUM_REQ-1:0][TKT_W-1:0]   issue_o,
   output logic [TKT_W-1:0]                next_q_o
);

   logic [TKT_W-1:0] next_q;
   logic [TKT_W-1:0] run [NUM_REQ+1];

   assign run[0] = next_q;

   // Ripple of ticket numbers in ascending requester order.
   for (genvar i = 0; i < NUM_REQ; i++) begin : g_issue
      assign issue_o[i] = run[i];
      assign run[i+1]   = take_i[i] ? run[i] + TKT_W'(1) : run[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) next_q <= '0;
      else        next_q <= run[NUM_REQ];
   end

   assign next_q_o = next_q;

endmodule

// File: rtl/tkt_slot.sv
module tkt_slot #(
   parameter int unsigned TKT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take_i,
   input  logic             retire_i,
   input  logic [TKT_W-1:0] issue_i,
   input  logic [TKT_W-1:0] serving_i,
   output logic             held_o,
   output logic             grant_o
);

   logic             held_q;
   logic [TKT_W-1:0] tkt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         tkt_q  <= '0;
      end else if (take_i) begin
         held_q <= 1'b1;
         tkt_q  <= issue_i;
      end else if (retire_i) begin
         held_q <= 1'b0;
      end
   end

   assign held_o  = held_q;
   assign grant_o = held_q && (tkt_q == serving_i);

endmodule

// File: rtl/tkt_server.sv
module tkt_server
   import ticket_lock_pkg::*;
#(
   parameter int unsigned NUM_REQ = 4,
   parameter int unsigned TKT_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_REQ-1:0] rel_i,
   input  logic [NUM_REQ-1:0] grant_i,
   output logic [NUM_REQ-1:0] retire_o,
   output logic [TKT_W-1:0]   serving_o,
   output logic               err_o
);

   logic [TKT_W-1:0] serving_q;
   logic             err_q;
   logic [NUM_REQ-1:0] bad_rel;
   rel_kind_e        kind;

   assign retire_o = rel_i & grant_i;
   assign bad_rel  = rel_i & ~grant_i;

   always_comb begin
      case ({|bad_rel, |retire_o})
         2'b01:   kind = REL_OWNER;
         2'b10:   kind = REL_BAD;
         2'b11:   kind = REL_BOTH;
         default: kind = REL_NONE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         serving_q <= '0;
         err_q     <= 1'b0;
      end else begin
         if (kind == REL_OWNER || kind == REL_BOTH)
            serving_q <= serving_q + TKT_W'(1);
         err_q <= (kind == REL_BAD || kind == REL_BOTH);
      end
   end

   assign serving_o = serving_q;
   assign err_o     = err_q;

endmodule

// File: rtl/ticket_lock_unit.sv
module ticket_lock_unit
   import ticket_lock_pkg::*;
#(
   parameter int unsigned NUM_REQ = 4,
   parameter int unsigned TKT_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_REQ-1:0] acq_i,
   input  logic [NUM_REQ-1:0] rel_i,
   output logic [NUM_REQ-1:0] grant_o,
   output logic [TKT_W-1:0]   next_ticket_o,
   output logic [TKT_W-1:0]   now_serving_o,
   output logic               rel_err_o
);

   localparam int unsigned MIN_W = min_ticket_width(NUM_REQ);

   if (NUM_REQ < 1) begin : g_bad_num
      $error("ticket_lock_unit: NUM_REQ must be at least 1");
   end
   if (TKT_W < MIN_W) begin : g_bad_width
      $error("ticket_lock_unit: TKT_W too small for NUM_REQ outstanding tickets");
   end

   logic [NUM_REQ-1:0]            slot_held;
   logic [NUM_REQ-1:0]            slot_take;
   logic [NUM_REQ-1:0]            slot_retire;
   logic [NUM_REQ-1:0][TKT_W-1:0] slot_issue;

   // A requester that already holds a ticket cannot take another.
   assign slot_take = acq_i & ~slot_held;

   tkt_dispenser #(.NUM_REQ(NUM_REQ), .TKT_W(TKT_W)) u_disp (
      .clk      (clk),
      .rst_n    (rst_n),
      .take_i   (slot_take),
      .issue_o  (slot_issue),
      .next_q_o (next_ticket_o)
   );

   for (genvar i = 0; i < NUM_REQ; i++) begin : g_slot
      tkt_slot #(.TKT_W(TKT_W)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .take_i    (slot_take[i]),
         .retire_i  (slot_retire[i]),
         .issue_i   (slot_issue[i]),
         .serving_i (now_serving_o),
         .held_o    (slot_held[i]),
         .grant_o   (grant_o[i])
      );
   end

   tkt_server #(.NUM_REQ(NUM_REQ), .TKT_W(TKT_W)) u_srv (
      .clk       (clk),
      .rst_n     (rst_n),
      .rel_i     (rel_i),
      .grant_i   (grant_o),
      .retire_o  (slot_retire),
      .serving_o (now_serving_o),
      .err_o     (rel_err_o)
   );

endmodule

// File: rtl/ticket_lock_chk.sv
module ticket_lock_chk #(
   parameter int unsigned NUM_REQ = 4,
   parameter int unsigned TKT_W   = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_REQ-1:0] acq_i,
   input logic [NUM_REQ-1:0] rel_i,
   input logic [NUM_REQ-1:0] grant_o,
   input logic [TKT_W-1:0]   next_ticket_o,
   input logic [TKT_W-1:0]   now_serving_o,
   input logic               rel_err_o,
   input logic [NUM_REQ-1:0] slot_held
);

   logic [TKT_W-1:0] gap;
   assign gap = next_ticket_o - now_serving_o;

   // R4: never two owners
   a_r4_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));

   // R4: an acquire into an idle lock is granted one cycle later
   a_r4_idle_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_held == '0 && acq_i != '0) |=> (grant_o != '0));

   // R2 / R3: dispense count moves by the number of accepted acquires
   a_r3_dispense_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> next_ticket_o ==
         $past(next_ticket_o) + TKT_W'($countones($past(acq_i & ~slot_held))));

   // R5: owner release advances serving by one
   a_r5_serve_step: assert property (@(posedge clk) disable iff (!rst_n)
      ((rel_i & grant_o) != '0) |=> now_serving_o == $past(now_serving_o) + TKT_W'(1));

   // R6: without an owner release the serving count holds
   a_r6_serve_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((rel_i & grant_o) == '0) |=> $stable(now_serving_o));

   // R6: non-owner release raises the flag for the next cycle
   a_r6_err_set: assert property (@(posedge clk) disable iff (!rst_n)
      ((rel_i & ~grant_o) != '0) |=> rel_err_o);

   // R6: no non-owner release means no flag
   a_r6_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ((rel_i & ~grant_o) == '0) |=> !rel_err_o);

   // R7: counter distance equals the number of ticket holders
   a_r7_no_alias: assert property (@(posedge clk) disable iff (!rst_n)
      TKT_W'($countones(slot_held)) == gap);

endmodule

bind ticket_lock_unit ticket_lock_chk #(.NUM_REQ(NUM_REQ), .TKT_W(TKT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .acq_i         (acq_i),
   .rel_i         (rel_i),
   .grant_o       (grant_o),
   .next_ticket_o (next_ticket_o),
   .now_serving_o (now_serving_o),
   .rel_err_o     (rel_err_o),
   .slot_held     (slot_held)
);

// File: tb/ticket_lock_unit_bench.sv
module ticket_lock_unit_bench;

   localparam int N = 4;
   localparam int W = 4;
   localparam int M = 1 << W;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] acq_i = '0;
   logic [N-1:0] rel_i = '0;
   logic [N-1:0] grant_o;
   logic [W-1:0] next_ticket_o;
   logic [W-1:0] now_serving_o;
   logic         rel_err_o;

   always #5 clk = ~clk;

   ticket_lock_unit #(.NUM_REQ(N), .TKT_W(W)) u_ticket_lock_unit (
      .clk(clk), .rst_n(rst_n), .acq_i(acq_i), .rel_i(rel_i),
      .grant_o(grant_o), .next_ticket_o(next_ticket_o),
      .now_serving_o(now_serving_o), .rel_err_o(rel_err_o)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // Reference model state
   int m_next = 0;
   int m_serv = 0;
   int m_held [N];
   int m_tkt  [N];
   int m_err  = 0;
   int order_q [$];      // requester indices in acceptance order
   int last_owner = -1;
   int wraps = 0;

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [N-1:0] model_grant();
      logic [N-1:0] g;
      for (int i = 0; i < N; i++) g[i] = (m_held[i] != 0) && (m_tkt[i] == m_serv);
      return g;
   endfunction

   task automatic compare_all();
      logic [N-1:0] g;
      g = model_grant();
      check("R4 grant", int'(grant_o), int'(g));
      check("R2 next_ticket", int'(next_ticket_o), m_next);
      check("R5 now_serving", int'(now_serving_o), m_serv);
      check("R6 rel_err", int'(rel_err_o), m_err);
      // R8: ownership order follows acceptance order
      for (int i = 0; i < N; i++) begin
         if (g[i] && i != last_owner) begin
            check("R8 owner order", i, order_q.size() > 0 ? order_q[0] : -1);
            last_owner = i;
         end
      end
   endtask

   // One cycle: drive after falling edge, let a rising edge pass, compare.
   task automatic step(input logic [N-1:0] a, input logic [N-1:0] r);
      logic [N-1:0] g;
      int held_old [N];
      acq_i = a;
      rel_i = r;
      g = model_grant();
      for (int i = 0; i < N; i++) held_old[i] = m_held[i];
      @(posedge clk);
      m_err = ((r & ~g) != '0) ? 1 : 0;
      if ((r & g) != '0) begin
         m_serv = (m_serv + 1) % M;
         for (int i = 0; i < N; i++)
            if (r[i] && g[i]) begin
               m_held[i] = 0;
               if (order_q.size() > 0) void'(order_q.pop_front());
               last_owner = -1;
            end
      end
      for (int i = 0; i < N; i++)
         if (a[i] && held_old[i] == 0) begin
            m_tkt[i]  = m_next;
            m_held[i] = 1;
            order_q.push_back(i);
            if (m_next == M - 1) wraps++;
            m_next = (m_next + 1) % M;
         end
      @(negedge clk);
      acq_i = '0;
      rel_i = '0;
      compare_all();
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      logic [N-1:0] a, r;
      for (int i = 0; i < N; i++) begin m_held[i] = 0; m_tkt[i] = 0; end
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 next_ticket reset", int'(next_ticket_o), 0);
      check("R1 now_serving reset", int'(now_serving_o), 0);
      check("R1 grant reset", int'(grant_o), 0);
      check("R1 rel_err reset", int'(rel_err_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      compare_all();

      // R4: first acquirer granted at once
      step(4'b0001, 4'b0000);
      check("R4 first grant", int'(grant_o), 4'b0001);
      // R3: simultaneous acquires numbered ascending
      step(4'b1110, 4'b0000);
      check("R3 next after three", int'(next_ticket_o), 4);
      // R2: acquire by a holder is ignored
      step(4'b0011, 4'b0000);
      check("R2 holder acquire ignored", int'(next_ticket_o), 4);
      // R6: non-owner release ignored, error flag
      step(4'b0000, 4'b0100);
      check("R6 bad release err", int'(rel_err_o), 1);
      check("R6 bad release serving", int'(now_serving_o), 0);
      check("R6 bad release grant", int'(grant_o), 4'b0001);
      step(4'b0000, 4'b0000);
      check("R6 err one cycle", int'(rel_err_o), 0);
      // R5 / R8: hand-over chain 0 -> 1 -> 2 -> 3
      step(4'b0000, 4'b0001);
      check("R5 handover to 1", int'(grant_o), 4'b0010);
      step(4'b0001, 4'b0010);
      check("R8 handover to 2", int'(grant_o), 4'b0100);
      step(4'b0000, 4'b0100);
      check("R8 handover to 3", int'(grant_o), 4'b1000);
      step(4'b0000, 4'b1000);
      check("R8 handover to 0 again", int'(grant_o), 4'b0001);
      // owner and non-owner release together
      step(4'b0000, 4'b0011);
      check("R6 mixed release err", int'(rel_err_o), 1);
      check("R5 mixed release serving", int'(now_serving_o), 5);

      // Pseudo-random traffic
      lfsr = 16'hACE1;
      for (int k = 0; k < 3000; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         a = lfsr[11:8] & lfsr[15:12];
         r = '0;
         if (lfsr[0] | lfsr[1]) r = model_grant();
         if (lfsr[5:2] == 4'hF) r = r | (N'(1) << lfsr[7:6]);
         step(a, r);
      end
      // R7: counters wrapped during the run
      check("R7 dispense wrapped", int'(wraps > 2), 1);
      check("R7 distance equals holders", int'(W'(next_ticket_o - now_serving_o)),
            m_held[0] + m_held[1] + m_held[2] + m_held[3]);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule